// File: doc/BRIEF.md
# Reference-Delay Sweep Calibrator

This block sits on the capture side of a multi-converter system and finds a good setting for the adjustable delay on a slave converter's reference-clock input. Each delay code from zero to a configured maximum is written out on a code port with a one-cycle strobe. The block then watches the slave's data clock through an external edge counter. It opens two back-to-back measurement windows, clears the counter at the start of each, and reads the toggle count at the end of each. A code is judged stable only when both counts land within a tolerance band around the expected toggle count. A clock that is stuck high, or one that toggles only now and then at the edge of a stable region, fails this test.

Stable codes form runs, and these are tracked on the fly. The block keeps the start and length of the open run and of the best run closed so far, so it needs no per-code memory. When the sweep ends, a code is chosen by fixed rules. If no code was unstable, the block picks the middle of the whole range. Otherwise it picks the midpoint of the longest stable run, and when two runs are equally long the lower one wins. The chosen code is written out once more, a done pulse is raised, and the choice is held on a separate output.

Top module: `dsw_sweep_ctrl`

## Requirements
- R1: After an accepted start, `code_o` steps through 0, 1, …, CODE_MAX in that order, with exactly one `code_wr_o` cycle per code. `code_o` never exceeds CODE_MAX.
- R2: For each code, the block runs two consecutive windows of WIN_LEN cycles each. `win_clr_o` is high for exactly the first cycle of each window, and `tog_cnt_i` is sampled in the window's last cycle.
- R3: A code is stable only if both window counts lie in EXP_TOG−TOL … EXP_TOG+TOL inclusive. A count outside that band in either window makes the code unstable, and this covers the intermittent case where only one window passes.
- R4: If no code in the sweep is unstable, the chosen code is floor(CODE_MAX/2).
- R5: Otherwise the chosen code is floor((first+last)/2) of the longest run of consecutive stable codes. A run still open at CODE_MAX counts as a run.
- R6: When two or more stable runs share the greatest length, the run with the lowest codes is chosen.
- R7: If every code is unstable, the chosen code is floor(CODE_MAX/2).
- R8: At the end of a sweep, `done_o` is high for exactly one cycle. In that cycle `code_wr_o` is high and `code_o` equals the chosen code. `sel_code_o` shows the chosen code from that cycle until the next sweep completes.
- R9: `busy_o` is high from the cycle after an accepted start through the `done_o` cycle. A `start_i` pulse while `busy_o` is high has no effect on the write sequence or on the result.
- R10: After reset, `busy_o`, `done_o`, `code_wr_o` and `win_clr_o` are low, and `code_o` and `sel_code_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Single-cycle request to begin a sweep |
| tog_cnt_i | input | CNT_W | Toggle count from the external edge counter |
| code_o | output | CODE_W | Delay code being applied |
| code_wr_o | output | 1 | One-cycle write strobe for `code_o` |
| win_clr_o | output | 1 | Clears the edge counter at a window's first cycle |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | One-cycle sweep-complete pulse |
| sel_code_o | output | CODE_W | Chosen code, held between sweeps |

## Verification
The bench builds the block with a 6-bit code field, CODE_MAX of 39, 8-cycle windows and an expected count of 4 with a tolerance of 1. A full sweep therefore takes well under a thousand cycles, and each toggle count can sit exactly on the tolerance edges (3 and 5) or just past them (2 and 6). With 40 codes, the bench can place every case it needs: runs that reach the top code, equal-length runs, codes that pass only one of the two windows, and sweeps that are fully stable or fully unstable.

// File: rtl/dsw_pkg.sv
package dsw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WRITE  = 3'd1,
        ST_MEAS   = 3'd2,
        ST_PICK   = 3'd3,
        ST_REPORT = 3'd4
    } dsw_state_e;

    typedef struct packed {
        logic done;
        logic stable;
    } dsw_verdict_t;

endpackage

// File: rtl/dsw_window_judge.sv
module dsw_window_judge
    import dsw_pkg::*;
#(
    parameter int WIN_LEN = 256,
    parameter int CNT_W   = 10,
    parameter int EXP_TOG = 128,
    parameter int TOL     = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [CNT_W-1:0] tog_cnt_i,
    output logic             win_clr_o,
    output dsw_verdict_t     verdict_o
);
    localparam int TMR_W = $clog2(WIN_LEN + 1);
    localparam logic [TMR_W-1:0] LAST_T = TMR_W'(WIN_LEN - 1);
    localparam logic [CNT_W:0]   LO_V   = (CNT_W+1)'(EXP_TOG - TOL);
    localparam logic [CNT_W:0]   HI_V   = (CNT_W+1)'(EXP_TOG + TOL);

    typedef struct packed {
        logic             active;
        logic             second;
        logic             first_ok;
        logic [TMR_W-1:0] timer;
        dsw_verdict_t     verdict;
    } judge_t;

    judge_t q, d;
    logic   in_band;

    always_comb begin
        in_band = ({1'b0, tog_cnt_i} >= LO_V) && ({1'b0, tog_cnt_i} <= HI_V);
        d = q;
        d.verdict = '0;
        if (!q.active) begin
            if (go_i) begin
                d.active   = 1'b1;
                d.second   = 1'b0;
                d.first_ok = 1'b0;
                d.timer    = '0;
            end
        end else if (q.timer == LAST_T) begin
            if (!q.second) begin
                d.second   = 1'b1;
                d.first_ok = in_band;
                d.timer    = '0;
            end else begin
                d.active         = 1'b0;
                d.second         = 1'b0;
                d.verdict.done   = 1'b1;
                d.verdict.stable = q.first_ok && in_band;
            end
        end else begin
            d.timer = q.timer + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign win_clr_o = q.active && (q.timer == '0);
    assign verdict_o = q.verdict;

    assert_clr_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_clr_o |=> !win_clr_o);
    assert_verdict_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        verdict_o.done |=> !verdict_o.done);
    assert_no_go_while_active_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.active && !(q.second && q.timer == LAST_T)) |=> q.active);

endmodule

// File: rtl/dsw_run_tracker.sv
module dsw_run_tracker #(
    parameter int CODE_W   = 10,
    parameter int CODE_MAX = 639
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              upd_i,
    input  logic              stable_i,
    input  logic [CODE_W-1:0] code_i,
    output logic [CODE_W-1:0] sel_code_o
);
    localparam int LEN_W = CODE_W + 1;
    localparam logic [CODE_W-1:0] MID_C   = CODE_W'(CODE_MAX / 2);
    localparam logic [CODE_W-1:0] MAX_C   = CODE_W'(CODE_MAX);
    localparam logic [LEN_W-1:0]  LEN_CAP = LEN_W'(CODE_MAX + 1);

    typedef struct packed {
        logic              in_run;
        logic [CODE_W-1:0] run_start;
        logic [LEN_W-1:0]  run_len;
        logic [CODE_W-1:0] best_start;
        logic [LEN_W-1:0]  best_len;
        logic              saw_bad;
    } trk_t;

    trk_t q, d;

    logic              use_open;
    logic [CODE_W-1:0] pick_start;
    logic [LEN_W-1:0]  pick_len;
    logic [LEN_W-1:0]  mid_sum;

    always_comb begin
        d = q;
        if (clr_i) begin
            d = '0;
        end else if (upd_i) begin
            if (stable_i) begin
                if (q.in_run) begin
                    d.run_len = q.run_len + 1'b1;
                end else begin
                    d.in_run    = 1'b1;
                    d.run_start = code_i;
                    d.run_len   = LEN_W'(1);
                end
            end else begin
                d.saw_bad = 1'b1;
                d.in_run  = 1'b0;
                if (q.in_run && (q.run_len > q.best_len)) begin
                    d.best_start = q.run_start;
                    d.best_len   = q.run_len;
                end
            end
        end
    end

    always_comb begin
        use_open   = q.in_run && (q.run_len > q.best_len);
        pick_start = use_open ? q.run_start : q.best_start;
        pick_len   = use_open ? q.run_len   : q.best_len;
        mid_sum    = {1'b0, pick_start} + ((pick_len - 1'b1) >> 1);
        if (!q.saw_bad || (pick_len == '0)) sel_code_o = MID_C;
        else                                sel_code_o = mid_sum[CODE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assert_sel_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sel_code_o <= MAX_C);
    assert_run_len_cap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (q.run_len <= LEN_CAP) && (q.best_len <= LEN_CAP));
    assert_best_grows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i) |=> (q.best_len >= $past(q.best_len)));

endmodule

// File: rtl/dsw_sweep_ctrl.sv
module dsw_sweep_ctrl
    import dsw_pkg::*;
#(
    parameter int CODE_W   = 10,
    parameter int CODE_MAX = 639,
    parameter int WIN_LEN  = 256,
    parameter int CNT_W    = 10,
    parameter int EXP_TOG  = 128,
    parameter int TOL      = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CNT_W-1:0]  tog_cnt_i,
    output logic [CODE_W-1:0] code_o,
    output logic              code_wr_o,
    output logic              win_clr_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] sel_code_o
);
    localparam logic [CODE_W-1:0] MAX_C = CODE_W'(CODE_MAX);

    typedef struct packed {
        dsw_state_e        st;
        logic [CODE_W-1:0] code;
        logic [CODE_W-1:0] sel;
    } ctl_t;

    ctl_t q, d;

    logic              judge_go;
    logic              trk_clr;
    logic              trk_upd;
    dsw_verdict_t      verdict;
    logic [CODE_W-1:0] trk_sel;

    dsw_window_judge #(
        .WIN_LEN (WIN_LEN),
        .CNT_W   (CNT_W),
        .EXP_TOG (EXP_TOG),
        .TOL     (TOL)
    ) u_judge (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_i      (judge_go),
        .tog_cnt_i (tog_cnt_i),
        .win_clr_o (win_clr_o),
        .verdict_o (verdict)
    );

    dsw_run_tracker #(
        .CODE_W   (CODE_W),
        .CODE_MAX (CODE_MAX)
    ) u_tracker (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (trk_clr),
        .upd_i      (trk_upd),
        .stable_i   (verdict.stable),
        .code_i     (q.code),
        .sel_code_o (trk_sel)
    );

    always_comb begin
        d        = q;
        judge_go = 1'b0;
        trk_clr  = 1'b0;
        trk_upd  = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (start_i) begin
                    trk_clr = 1'b1;
                    d.code  = '0;
                    d.st    = ST_WRITE;
                end
            end
            ST_WRITE: begin
                judge_go = 1'b1;
                d.st     = ST_MEAS;
            end
            ST_MEAS: begin
                if (verdict.done) begin
                    trk_upd = 1'b1;
                    if (q.code == MAX_C) begin
                        d.st = ST_PICK;
                    end else begin
                        d.code = q.code + 1'b1;
                        d.st   = ST_WRITE;
                    end
                end
            end
            ST_PICK: begin
                d.sel  = trk_sel;
                d.code = trk_sel;
                d.st   = ST_REPORT;
            end
            ST_REPORT: d.st = ST_IDLE;
            default:   d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_IDLE;
            q.code <= '0;
            q.sel  <= '0;
        end else begin
            q <= d;
        end
    end

    assign code_o     = q.code;
    assign sel_code_o = q.sel;
    assign code_wr_o  = (q.st == ST_WRITE) || (q.st == ST_REPORT);
    assign done_o     = (q.st == ST_REPORT);
    assign busy_o     = (q.st != ST_IDLE);

    assert_code_cap_R1: assert property (@(posedge clk) disable iff (!rst_n)
        code_o <= MAX_C);
    assert_write_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (code_wr_o && !done_o) |=> $stable(code_o));
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
    assert_done_writes_sel_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (code_wr_o && (code_o == sel_code_o)));
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);
    assert_sel_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> (done_o || $stable(sel_code_o)));

endmodule

// File: tb/dsw_sweep_ctrl_tb.sv
module dsw_sweep_ctrl_tb;
    localparam int CLK_P    = 10;
    localparam int CODE_W   = 6;
    localparam int CODE_MAX = 39;
    localparam int WIN_LEN  = 8;
    localparam int CNT_W    = 6;
    localparam int EXP_TOG  = 4;
    localparam int TOL      = 1;
    localparam int NVEC     = 7;

    typedef struct packed {
        logic [63:0] m1;
        logic [63:0] m2;
        logic [7:0]  want;
    } vec_t;

    function automatic logic [63:0] rm(int lo, int hi);
        logic [63:0] m;
        m = '0;
        for (int i = lo; i <= hi; i++) m[i] = 1'b1;
        return m;
    endfunction

    localparam logic [63:0] ALL = rm(0, CODE_MAX);

    // m1: codes that pass window one; m2: codes that pass window two
    localparam vec_t VECS [NVEC] = '{
        '{ALL, ALL, 8'd19},                                        // R4 all stable
        '{ALL & ~rm(10,14), ALL & ~rm(10,14), 8'd27},              // R5 one bad run
        '{ALL & ~rm(5,7) & ~rm(25,29), ALL & ~rm(5,7) & ~rm(25,29), 8'd16}, // R5 two bad runs
        '{ALL & ~rm(12,15) & ~rm(28,31), ALL & ~rm(12,15) & ~rm(28,31), 8'd5}, // R6 tie
        '{64'd0, 64'd0, 8'd19},                                    // R7 all bad
        '{ALL & ~rm(20,24), ALL & ~rm(18,23), 8'd8},               // R3 intermittent
        '{ALL & ~rm(0,2), ALL & ~rm(0,2), 8'd21}                   // R5 run open at top
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0;
    logic [CNT_W-1:0]  tog_cnt_i = '0;
    logic [CODE_W-1:0] code_o;
    logic              code_wr_o;
    logic              win_clr_o;
    logic              busy_o;
    logic              done_o;
    logic [CODE_W-1:0] sel_code_o;

    int n_chk = 0;
    int n_bad = 0;

    logic [63:0] cur_m1 = '0;
    logic [63:0] cur_m2 = '0;
    int nwin = 0;
    int wr_cnt = 0;
    int seq_err = 0;
    int exp_next = 0;

    always #(CLK_P/2) clk = ~clk;

    dsw_sweep_ctrl #(
        .CODE_W   (CODE_W),
        .CODE_MAX (CODE_MAX),
        .WIN_LEN  (WIN_LEN),
        .CNT_W    (CNT_W),
        .EXP_TOG  (EXP_TOG),
        .TOL      (TOL)
    ) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .tog_cnt_i  (tog_cnt_i),
        .code_o     (code_o),
        .code_wr_o  (code_wr_o),
        .win_clr_o  (win_clr_o),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .sel_code_o (sel_code_o)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Edge-counter model and write monitor, updated away from the rising edge
    initial begin
        forever begin
            @(negedge clk);
            if (code_wr_o) begin
                wr_cnt++;
                nwin = 0;
                if (!done_o) begin
                    if (int'(code_o) != exp_next) seq_err++;
                    exp_next++;
                end
            end else if (win_clr_o) begin
                nwin++;
            end
            begin
                logic good;
                int   v;
                good = (nwin <= 1) ? cur_m1[code_o] : cur_m2[code_o];
                if (good) v = EXP_TOG - 1 + (int'(code_o) % 3);
                else if (code_o[0]) v = EXP_TOG + 2;
                else if (code_o[1]) v = EXP_TOG - 2;
                else v = 0;
                tog_cnt_i = CNT_W'(v);
            end
        end
    end

    task automatic sweep(int idx, bit inject);
        int got_done;
        logic [CODE_W-1:0] held;
        cur_m1   = VECS[idx].m1;
        cur_m2   = VECS[idx].m2;
        wr_cnt   = 0;
        seq_err  = 0;
        exp_next = 0;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        got_done = 0;
        for (int c = 0; c < 5000; c++) begin
            if (inject && c == 150) start_i = 1'b1;
            if (inject && c == 151) start_i = 1'b0;
            if (inject && c == 300) check("R9 busy during sweep", int'(busy_o), 1);
            #1;
            if (done_o) begin got_done = 1; break; end
            @(negedge clk);
        end
        check("R8 done seen", got_done, 1);
        check("R4-7 selected code", int'(sel_code_o), int'(VECS[idx].want));
        check("R8 write at done", int'(code_wr_o), 1);
        check("R8 code_o at done", int'(code_o), int'(VECS[idx].want));
        check("R9 busy at done", int'(busy_o), 1);
        held = sel_code_o;
        @(negedge clk);
        #1;
        check("R8 done one cycle", int'(done_o), 0);
        check("R1 write count", wr_cnt, CODE_MAX + 2);
        check("R1 ascending codes", seq_err, 0);
        check("R1 last code", exp_next, CODE_MAX + 1);
        repeat (3) @(negedge clk);
        check("R8 selection held", int'(sel_code_o), int'(held));
        check("R9 idle after done", int'(busy_o), 0);
    endtask

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 busy", int'(busy_o), 0);
        check("R10 done", int'(done_o), 0);
        check("R10 write", int'(code_wr_o), 0);
        check("R10 clear", int'(win_clr_o), 0);
        check("R10 code", int'(code_o), 0);
        check("R10 sel", int'(sel_code_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 idle after release", int'(busy_o), 0);

        for (int i = 0; i < NVEC; i++) sweep(i, 1'b0);

        // R9: start pulse in the middle of a sweep is ignored
        sweep(1, 1'b1);

        // R2: window timing for one code at fresh start
        cur_m1 = ALL;
        cur_m2 = ALL;
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check("R2 write before window", int'(code_wr_o), 1);
        @(negedge clk); #1;
        check("R2 clear first window", int'(win_clr_o), 1);
        @(negedge clk); #1;
        check("R2 clear one cycle", int'(win_clr_o), 0);
        repeat (WIN_LEN - 1) @(negedge clk);
        #1;
        check("R2 clear second window", int'(win_clr_o), 1);
        repeat (WIN_LEN) @(negedge clk);
        #1;
        check("R2 verdict cycle", int'(code_wr_o), 0);
        @(negedge clk); #1;
        check("R2 next code write", int'(code_wr_o), 1);
        check("R1 next code value", int'(code_o), 1);

        // R10: reset mid-sweep returns to idle
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        #1;
        check("R10 busy after reset", int'(busy_o), 0);
        check("R10 code after reset", int'(code_o), 0);
        rst_n = 1'b1;

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule